// File: doc/BRIEF.md
# Control Register Access Permission Checker

This block decides whether an access to a 12-bit control register address is allowed. It gives a verdict one cycle after a request strobe. The rights come from fixed fields of the address rather than from a table per register. The two top bits mark a register as read-only or read/write. The next two bits give the lowest privilege level that may touch it. A window of sixteen addresses at 0x7B0 is open only to the debug mode.

An external table decides whether a register exists and whether it is an upper-half alias of a 64-bit register. These decisions arrive as the `present` and `hi_half` inputs. The block combines them with the current privilege level, the debug-mode flag, the register-width mode and the read and write intent. When a request is refused, it reports a single cause code. The code is chosen by a fixed priority, so that the trap logic downstream sees the same reason for the same access every time.

Top module: `csr_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `verdict_vld`, `allow`, `illegal` and `cause` are all zero.
- R2: A strobe on `req_vld` at a clock edge yields `verdict_vld`=1 and the verdict from the next edge onward. An edge with no strobe yields `verdict_vld`=0, `allow`=0, `illegal`=0 and `cause`=0 at the next edge.
- R3: On every valid verdict, exactly one of `allow` and `illegal` is 1. An allowed verdict always carries cause 0.
- R4: Privilege is encoded as U=00, S=01, H=10, M=11. An access is refused with cause 3 when the privilege is numerically below address bits [9:8]. Any equal or higher level passes this check.
- R5: When address bits [11:10] are 2'b11 the register is read-only. A write to it is refused with cause 5. A read of it passes this check.
- R6: Addresses 0x7B0 to 0x7BF are refused with cause 4 unless `dbg_mode` is 1. Addresses 0x7A0 to 0x7AF are ordinary machine read/write registers.
- R7: While `dbg_mode` is 1, the access is judged as if the privilege were M, whatever `priv` holds.
- R8: An access with `present`=0 is refused with cause 1.
- R9: An access with `hi_half`=1 is refused with cause 2 when `wide64`=1. The same access is judged normally when `wide64`=0.
- R10: When several faults apply, the reported cause is the lowest of them: 1, then 2, then 3, then 4, then 5.
- R11: A strobe with both `rd_en` and `wr_en` at 0 carries no access. It is answered with `allow`=1 and cause 0 whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| addr | input | 12 | Register address |
| priv | input | 2 | Current privilege (U=00, S=01, H=10, M=11) |
| dbg_mode | input | 1 | Core is in debug mode |
| wide64 | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| rd_en | input | 1 | Access reads the register |
| wr_en | input | 1 | Access writes the register |
| present | input | 1 | Register exists, from the presence table |
| hi_half | input | 1 | Address is an upper-half alias, from the presence table |
| verdict_vld | output | 1 | Verdict valid this cycle |
| allow | output | 1 | Access permitted |
| illegal | output | 1 | Access raises an illegal-instruction exception |
| cause | output | 3 | Refusal reason: 0 none, 1 absent, 2 upper half in 64-bit mode, 3 privilege too low, 4 debug window, 5 write to read-only |

## Verification
Every result of this block lands exactly one clock edge after the strobe that asked for it. All four outputs pass through a single register stage after the combinational checks. The bench drives each request on a falling edge and lets one rising edge capture it. It then reads `verdict_vld`, `allow`, `illegal` and `cause` on the following falling edge, before the next request is driven. Idle cycles are checked the same way, one edge after the strobe drops, so a verdict that lingers or arrives a cycle late shows up as a mismatch.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    localparam int ADDR_W   = 12;
    localparam int CAUSE_W  = 3;
    localparam int NUM_FLT  = 5;

    typedef enum logic [1:0] {
        LVL_U = 2'b00,
        LVL_S = 2'b01,
        LVL_H = 2'b10,
        LVL_M = 2'b11
    } lvl_e;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_NONE      = 3'd0,
        CZ_ABSENT    = 3'd1,
        CZ_HALF64    = 3'd2,
        CZ_PRIV_LOW  = 3'd3,
        CZ_DBG_WIN   = 3'd4,
        CZ_RO_WRITE  = 3'd5
    } cause_e;

    // Fault vector bit i corresponds to cause code i+1; lower index wins.
    localparam int FI_ABSENT   = 0;
    localparam int FI_HALF64   = 1;
    localparam int FI_PRIV_LOW = 2;
    localparam int FI_DBG_WIN  = 3;
    localparam int FI_RO_WRITE = 4;

    typedef struct packed {
        logic [1:0] rw_bits;
        lvl_e       min_lvl;
        logic       dbg_win;
    } addr_info_t;

    typedef struct packed {
        lvl_e       lvl;
        logic       dbg;
        logic       w64;
        logic       rd;
        logic       wr;
        logic       present;
        logic       hi_half;
    } ctx_t;

    typedef struct packed {
        logic       vld;
        logic       allow;
        logic       illegal;
        cause_e     cause;
    } verdict_t;

    function automatic lvl_e eff_level(input lvl_e lvl, input logic dbg);
        return dbg ? LVL_M : lvl;
    endfunction

    function automatic logic level_ok(input lvl_e have, input lvl_e need);
        return (have >= need);
    endfunction

endpackage

// File: rtl/csr_gate_decode.sv
module csr_gate_decode
    import csr_gate_pkg::*;
#(
    parameter int                AW           = ADDR_W,
    parameter logic [AW-1:0]     DBG_BASE     = 12'h7B0,
    parameter int                DBG_SPAN_LOG2 = 4
) (
    input  logic [AW-1:0] addr,
    output addr_info_t    info
);
    localparam int RW_HI  = AW - 1;
    localparam int LVL_HI = AW - 3;
    localparam logic [AW-1:0] SPAN_MASK = (AW'(1) << DBG_SPAN_LOG2) - AW'(1);

    always_comb begin
        info.rw_bits = addr[RW_HI -: 2];
        info.min_lvl = lvl_e'(addr[LVL_HI -: 2]);
        info.dbg_win = ((addr & ~SPAN_MASK) == (DBG_BASE & ~SPAN_MASK));
    end

endmodule

// File: rtl/csr_gate_rules.sv
module csr_gate_rules
    import csr_gate_pkg::*;
(
    input  addr_info_t          info,
    input  ctx_t                ctx,
    output logic [NUM_FLT-1:0]  faults
);
    lvl_e eff;
    logic any_intent;

    always_comb begin
        eff        = eff_level(ctx.lvl, ctx.dbg);
        any_intent = ctx.rd | ctx.wr;
        faults     = '0;
        if (any_intent) begin
            faults[FI_ABSENT]   = ~ctx.present;
            faults[FI_HALF64]   = ctx.hi_half & ctx.w64;
            faults[FI_PRIV_LOW] = ~level_ok(eff, info.min_lvl);
            faults[FI_DBG_WIN]  = info.dbg_win & ~ctx.dbg;
            faults[FI_RO_WRITE] = (info.rw_bits == 2'b11) & ctx.wr;
        end
    end

endmodule

// File: rtl/csr_gate_pick.sv
module csr_gate_pick
    import csr_gate_pkg::*;
#(
    parameter int N = NUM_FLT
) (
    input  logic [N-1:0]       faults,
    output logic               any_fault,
    output logic [CAUSE_W-1:0] code
);
    logic [N:0]           seen;
    logic [N-1:0]         first;
    logic [CAUSE_W-1:0]   part [N+1];

    assign seen[0] = 1'b0;
    assign part[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign first[i]  = faults[i] & ~seen[i];
        assign seen[i+1] = seen[i] | faults[i];
        assign part[i+1] = part[i] | (first[i] ? CAUSE_W'(i + 1) : '0);
    end

    assign any_fault = seen[N];
    assign code      = part[N];

endmodule

// File: rtl/csr_gate.sv
module csr_gate
    import csr_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_vld,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          priv,
    input  logic                dbg_mode,
    input  logic                wide64,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic                present,
    input  logic                hi_half,
    output logic                verdict_vld,
    output logic                allow,
    output logic                illegal,
    output logic [CAUSE_W-1:0]  cause
);
    addr_info_t          info;
    ctx_t                ctx;
    logic [NUM_FLT-1:0]  faults;
    logic                any_fault;
    logic [CAUSE_W-1:0]  code;
    verdict_t            nxt, cur;

    assign ctx = '{lvl: lvl_e'(priv), dbg: dbg_mode, w64: wide64,
                   rd: rd_en, wr: wr_en, present: present, hi_half: hi_half};

    csr_gate_decode #(.AW(ADDR_W)) u_decode (
        .addr (addr),
        .info (info)
    );

    csr_gate_rules u_rules (
        .info   (info),
        .ctx    (ctx),
        .faults (faults)
    );

    csr_gate_pick #(.N(NUM_FLT)) u_pick (
        .faults    (faults),
        .any_fault (any_fault),
        .code      (code)
    );

    always_comb begin
        nxt = '0;
        if (req_vld) begin
            nxt.vld     = 1'b1;
            nxt.allow   = ~any_fault;
            nxt.illegal = any_fault;
            nxt.cause   = cause_e'(code);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign verdict_vld = cur.vld;
    assign allow       = cur.allow;
    assign illegal     = cur.illegal;
    assign cause       = cur.cause;

endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_vld,
    input logic [3:0] addr_hi,
    input logic [1:0] priv,
    input logic       dbg_mode,
    input logic       wide64,
    input logic       rd_en,
    input logic       wr_en,
    input logic       present,
    input logic       hi_half,
    input logic       verdict_vld,
    input logic       allow,
    input logic       illegal,
    input logic [2:0] cause
);
    a_r2_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> verdict_vld);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!verdict_vld && !allow && !illegal && cause == 3'd0));

    a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
        verdict_vld |-> $onehot({allow, illegal}));

    a_r3_allow_no_cause: assert property (@(posedge clk) disable iff (rst)
        allow |-> cause == 3'd0);

    a_r4_priv_low: assert property (@(posedge clk) disable iff (rst)
        (req_vld && (rd_en || wr_en) && !dbg_mode && priv < addr_hi[1:0]) |=> illegal);

    a_r5_ro_write: assert property (@(posedge clk) disable iff (rst)
        (req_vld && wr_en && addr_hi[3:2] == 2'b11) |=> !allow);

    a_r8_absent: assert property (@(posedge clk) disable iff (rst)
        (req_vld && (rd_en || wr_en) && !present) |=> (illegal && cause == 3'd1));

    a_r9_half64: assert property (@(posedge clk) disable iff (rst)
        (req_vld && (rd_en || wr_en) && present && hi_half && wide64) |=> cause == 3'd2);

    a_r11_no_intent: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !rd_en && !wr_en) |=> allow);

endmodule

bind csr_gate csr_gate_chk u_csr_gate_chk (
    .clk         (clk),
    .rst         (rst),
    .req_vld     (req_vld),
    .addr_hi     (addr[11:8]),
    .priv        (priv),
    .dbg_mode    (dbg_mode),
    .wide64      (wide64),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .present     (present),
    .hi_half     (hi_half),
    .verdict_vld (verdict_vld),
    .allow       (allow),
    .illegal     (illegal),
    .cause       (cause)
);

// File: tb/csr_gate_bench.sv
module csr_gate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  priv = '0;
    logic        dbg_mode = 1'b0;
    logic        wide64 = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        present = 1'b0;
    logic        hi_half = 1'b0;
    logic        verdict_vld, allow, illegal;
    logic [2:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    csr_gate u_csr_gate (
        .clk(clk), .rst(rst), .req_vld(req_vld), .addr(addr), .priv(priv),
        .dbg_mode(dbg_mode), .wide64(wide64), .rd_en(rd_en), .wr_en(wr_en),
        .present(present), .hi_half(hi_half), .verdict_vld(verdict_vld),
        .allow(allow), .illegal(illegal), .cause(cause)
    );

    task automatic check_out(input string tag, input logic ev, input logic ea,
                             input logic ei, input logic [2:0] ec);
        checks++;
        if ({verdict_vld, allow, illegal, cause} !== {ev, ea, ei, ec}) begin
            errors++;
            $display("FAIL %s: got vld=%0b allow=%0b illegal=%0b cause=%0d, expected vld=%0b allow=%0b illegal=%0b cause=%0d",
                     tag, verdict_vld, allow, illegal, cause, ev, ea, ei, ec);
        end
    endtask

    // Drive one request on a falling edge, sample one rising edge later.
    task automatic probe(input string tag, input logic [11:0] a, input logic [1:0] p,
                         input logic d, input logic w64, input logic r, input logic w,
                         input logic pres, input logic hh, input logic [2:0] exp_cause);
        addr = a; priv = p; dbg_mode = d; wide64 = w64;
        rd_en = r; wr_en = w; present = pres; hi_half = hh; req_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out(tag, 1'b1, exp_cause == 3'd0, exp_cause != 3'd0, exp_cause);
    endtask

    task automatic t_reset;
        check_out("R1 during reset", 1'b0, 1'b0, 1'b0, 3'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R1 after reset", 1'b0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_privilege;
        probe("R4 U read user reg",        12'h001, 2'b00, 0, 0, 1, 0, 1, 0, 3'd0);
        probe("R4 U read super reg",       12'h100, 2'b00, 0, 0, 1, 0, 1, 0, 3'd3);
        probe("R4 S write super reg",      12'h100, 2'b01, 0, 0, 0, 1, 1, 0, 3'd0);
        probe("R4 S read hyper reg",       12'h600, 2'b01, 0, 0, 1, 0, 1, 0, 3'd3);
        probe("R4 H read hyper reg",       12'h600, 2'b10, 0, 0, 1, 0, 1, 0, 3'd0);
        probe("R4 H write machine reg",    12'h300, 2'b10, 0, 0, 0, 1, 1, 0, 3'd3);
        probe("R4 M read super reg",       12'h100, 2'b11, 0, 0, 1, 0, 1, 0, 3'd0);
    endtask

    task automatic t_readonly;
        probe("R5 U write ro reg",         12'hC00, 2'b00, 0, 0, 0, 1, 1, 0, 3'd5);
        probe("R5 U read ro reg",          12'hC00, 2'b00, 0, 0, 1, 0, 1, 0, 3'd0);
        probe("R5 M rw ro reg",            12'hF11, 2'b11, 0, 0, 1, 1, 1, 0, 3'd5);
        probe("R10 low priv beats ro",     12'hF11, 2'b01, 0, 0, 0, 1, 1, 0, 3'd3);
    endtask

    task automatic t_debug;
        probe("R6 M debug window no dbg",  12'h7B3, 2'b11, 0, 0, 1, 0, 1, 0, 3'd4);
        probe("R6 M debug window dbg",     12'h7B3, 2'b11, 1, 0, 0, 1, 1, 0, 3'd0);
        probe("R6 M shared window",        12'h7A8, 2'b11, 0, 0, 0, 1, 1, 0, 3'd0);
        probe("R6 edge 0x7BF no dbg",      12'h7BF, 2'b11, 0, 0, 1, 0, 1, 0, 3'd4);
        probe("R6 edge 0x7C0 no dbg",      12'h7C0, 2'b11, 0, 0, 1, 0, 1, 0, 3'd0);
        probe("R10 S debug window",        12'h7B0, 2'b01, 0, 0, 1, 0, 1, 0, 3'd3);
        probe("R7 U in dbg machine reg",   12'h300, 2'b00, 1, 0, 1, 0, 1, 0, 3'd0);
        probe("R7 U in dbg debug window",  12'h7B0, 2'b00, 1, 0, 0, 1, 1, 0, 3'd0);
    endtask

    task automatic t_absent;
        probe("R8 absent otherwise ok",    12'h300, 2'b11, 0, 0, 1, 0, 0, 0, 3'd1);
        probe("R10 absent beats priv",     12'h300, 2'b00, 0, 1, 0, 1, 0, 1, 3'd1);
    endtask

    task automatic t_half;
        probe("R9 half alias 64-bit",      12'hC80, 2'b00, 0, 1, 1, 0, 1, 1, 3'd2);
        probe("R9 half alias 32-bit",      12'hC80, 2'b00, 0, 0, 1, 0, 1, 1, 3'd0);
        probe("R9 plain reg 64-bit",       12'hC00, 2'b00, 0, 1, 1, 0, 1, 0, 3'd0);
        probe("R10 half beats priv",       12'h312, 2'b00, 0, 1, 1, 0, 1, 1, 3'd2);
    endtask

    task automatic t_no_intent;
        probe("R11 no intent bad access",  12'hF11, 2'b00, 0, 1, 0, 0, 0, 1, 3'd0);
    endtask

    task automatic t_idle;
        probe("R2 request before idle",    12'h100, 2'b00, 0, 0, 1, 0, 1, 0, 3'd3);
        req_vld = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R2 idle clears verdict", 1'b0, 1'b0, 1'b0, 3'd0);
        @(posedge clk); @(negedge clk);
        check_out("R2 idle stays clear", 1'b0, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_privilege();
        t_readonly();
        t_debug();
        t_absent();
        t_half();
        t_no_intent();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule